// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block is a host-side SPI master that runs one conversion on a serial 10-bit ADC and returns the result. A single start request makes it drive select low and run a fixed 24-clock transaction in clock mode 0. The serial clock idles low, the host changes data on falling edges and samples on rising edges. The first byte sent is a command byte. It carries a start bit, the channel and input-mode fields, and the code that makes the converter use the serial clock for its conversion steps. The two bytes after it are sent as zeros while the reply is captured.

The byte received during the command is discarded. The converter returns its answer across the second and third received bytes: one leading zero, ten result bits with the most significant first, two sub-bits, and three trailing zeros. The reader pulls out the result and the sub-bits and presents them with a one-cycle valid pulse as select returns high.

The serial clock rate comes from a half-period divider input in system clocks. Because the sample held inside the converter droops, the time from the hold instant to the capture of the last result bit is limited by a cycle budget parameter. Any frame that overruns the budget is flagged.

Top module: `adc_conv_reader`

## Requirements
- R1: After reset, select (`cs_n_o`) is high, the serial clock is low, `mosi_o` is low, `valid_o` and `busy_o` are low, and `result_o`, `sub_o` and `timing_err_o` are zero.
- R2: The serial clock is low whenever select is high. Each frame has exactly 24 rising edges. `mosi_o` changes only in the cycle where the serial clock falls, or when select falls. `miso_i` is sampled in the cycle where the serial clock rises.
- R3: Each serial clock phase lasts H system cycles. H is `div_i` latched when the start is accepted, and a value of 0 is taken as 1. Select falls in the cycle after the accepted start, and the first rising edge comes H cycles after that.
- R4: The first byte is sent MSB first as {1, s2, s1, s0, uni, sgl, 1, 1}. Here s2 = `chan_i[0]`, s1 = `chan_i[2]` and s0 = `chan_i[1]`; uni is `unipolar_i` (1 = unipolar) and sgl is `single_i` (1 = single-ended). The channel and mode inputs are sampled only when the start is accepted.
- R5: The second and third transmitted bytes are all zeros.
- R6: Number the received bits 0 to 23 in arrival order. `result_o` takes bits 9..18, with bit 9 as its MSB, and `sub_o` takes bits 19..20, with bit 19 as its MSB. All other received bits, including the whole first byte, have no effect on the outputs.
- R7: Select returns high H cycles after the 24th falling edge. `valid_o` is high for exactly that one cycle, which comes 49·H cycles after the accepted start.
- R8: A start request while a frame is in progress is ignored. The running frame and its command are unchanged, and no second frame follows.
- R9: The hold window runs from the falling edge that ends received bit 7 to the rising edge that samples bit 18, and lasts 21·H cycles. `timing_err_o` is set with `valid_o` to 1 when the window exceeds `BUDGET_CYC` cycles, and to 0 otherwise.
- R10: `result_o`, `sub_o` and `timing_err_o` hold their values until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| chan_i | input | 3 | Channel number |
| unipolar_i | input | 1 | 1 = unipolar coding, 0 = bipolar |
| single_i | input | 1 | 1 = single-ended input, 0 = differential |
| div_i | input | DIV_W | Serial clock half-period in system cycles |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low select |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | Frame in progress |
| result_o | output | 10 | Conversion result |
| sub_o | output | 2 | Sub-bits following the result |
| valid_o | output | 1 | One-cycle pulse when a frame completes |
| timing_err_o | output | 1 | Hold window exceeded the cycle budget |

## Verification
The bound checker watches the things that hold on every cycle:
- the clock is idle low while select is high;
- the data line moves only on falling clock edges;
- valid is a single-cycle pulse that coincides with select rising;
- select can only fall after a start accepted while idle.

Other behaviour only shows up in the bench scenarios against a model converter: the exact command byte and channel bit mapping, the zero filler bytes, which received bit positions reach the result, the 49·H completion time, the first-edge delay, and the error flag on both sides of the budget boundary.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    localparam int FRAME_BITS = 24;
    localparam int CMD_BITS   = 8;
    localparam int LEAD_BITS  = 1;
    localparam int RES_W      = 10;
    localparam int SUB_W      = 2;
    localparam int CAP_W      = RES_W + SUB_W;
    localparam int FIRST_CAP  = CMD_BITS + LEAD_BITS;
    localparam int LAST_RES   = FIRST_CAP + RES_W - 1;
    localparam int LAST_CAP   = FIRST_CAP + CAP_W - 1;
    localparam int HOLD_BIT   = CMD_BITS - 1;
    localparam logic [1:0] PD_EXT_CLK = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/adc_cmd_pack.sv
module adc_cmd_pack
    import adc_rd_pkg::*;
(
    input  logic [2:0]          chan_i,
    input  logic                unipolar_i,
    input  logic                single_i,
    output logic [CMD_BITS-1:0] cmd_o
);
    // channel select field order: low channel bit first, then bit 2, then bit 1
    always_comb begin
        cmd_o = {1'b1, chan_i[0], chan_i[2], chan_i[1], unipolar_i, single_i, PD_EXT_CLK};
    end
endmodule

// File: rtl/adc_frame_unpack.sv
module adc_frame_unpack
    import adc_rd_pkg::*;
(
    input  logic [CAP_W-1:0] cap_i,
    output logic [RES_W-1:0] res_o,
    output logic [SUB_W-1:0] sub_o
);
    always_comb begin
        res_o = cap_i[CAP_W-1 -: RES_W];
        sub_o = cap_i[SUB_W-1:0];
    end
endmodule

// File: rtl/hold_window_timer.sv
module hold_window_timer #(
    parameter int BUDGET_CYC = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic check_i,
    output logic late_o
);
    localparam int CW = $clog2(BUDGET_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(BUDGET_CYC);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (open_i) begin
            d.run = 1'b1;
            d.cnt = '0;
        end else if (check_i) begin
            d.run = 1'b0;
        end else if (q.run && (q.cnt != LIMIT)) begin
            d.cnt = q.cnt + CW'(1);
        end
        // elapsed cycles at the check edge equal cnt + 1
        late_o = q.run && (q.cnt >= LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_conv_reader.sv
module adc_conv_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV_W      = 10,
    parameter int BUDGET_CYC = 15000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       chan_i,
    input  logic             unipolar_i,
    input  logic             single_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             miso_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o,
    output logic [SUB_W-1:0] sub_o,
    output logic             valid_o,
    output logic             timing_err_o
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0] HOLD_IDX   = BW'(HOLD_BIT);
    localparam logic [BW-1:0] CHECK_IDX  = BW'(LAST_RES);
    localparam logic [BW-1:0] CAP_LO_IDX = BW'(FIRST_CAP);
    localparam logic [BW-1:0] CAP_HI_IDX = BW'(LAST_CAP);
    localparam int PAD_BITS = FRAME_BITS - CMD_BITS;

    typedef struct packed {
        rd_state_e             state;
        logic                  cs_n;
        logic                  sclk;
        logic [DIV_W-1:0]      cnt;
        logic [DIV_W-1:0]      half;
        logic [BW-1:0]         bitn;
        logic [FRAME_BITS-1:0] tx;
        logic [CAP_W-1:0]      cap;
        logic [RES_W-1:0]      res;
        logic [SUB_W-1:0]      sub;
        logic                  err_run;
        logic                  err;
        logic                  valid;
    } regs_t;

    regs_t d, q;

    logic [CMD_BITS-1:0] cmd_w;
    logic [RES_W-1:0]    res_w;
    logic [SUB_W-1:0]    sub_w;
    logic                late_w;
    logic                win_open, win_check;
    logic                phase_end;

    adc_cmd_pack u_cmd (
        .chan_i     (chan_i),
        .unipolar_i (unipolar_i),
        .single_i   (single_i),
        .cmd_o      (cmd_w)
    );

    adc_frame_unpack u_unpack (
        .cap_i (q.cap),
        .res_o (res_w),
        .sub_o (sub_w)
    );

    hold_window_timer #(.BUDGET_CYC(BUDGET_CYC)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (win_open),
        .check_i (win_check),
        .late_o  (late_w)
    );

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        win_open  = 1'b0;
        win_check = 1'b0;
        phase_end = (q.cnt == (q.half - DIV_W'(1)));

        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state   = ST_SHIFT;
                    d.cs_n    = 1'b0;
                    d.sclk    = 1'b0;
                    d.cnt     = '0;
                    d.half    = (div_i == '0) ? DIV_W'(1) : div_i;
                    d.bitn    = '0;
                    d.tx      = {cmd_w, {PAD_BITS{1'b0}}};
                    d.cap     = '0;
                    d.err_run = 1'b0;
                end
            end

            ST_SHIFT: begin
                if (phase_end) begin
                    d.cnt = '0;
                    if (!q.sclk) begin
                        // rising edge: sample the reply bit
                        d.sclk = 1'b1;
                        if ((q.bitn >= CAP_LO_IDX) && (q.bitn <= CAP_HI_IDX)) begin
                            d.cap = {q.cap[CAP_W-2:0], miso_i};
                        end
                        if (q.bitn == CHECK_IDX) begin
                            win_check = 1'b1;
                            d.err_run = late_w;
                        end
                    end else begin
                        // falling edge: advance the outgoing bit
                        d.sclk = 1'b0;
                        d.tx   = {q.tx[FRAME_BITS-2:0], 1'b0};
                        if (q.bitn == HOLD_IDX) begin
                            win_open = 1'b1;
                        end
                        if (q.bitn == LAST_BIT) begin
                            d.state = ST_TAIL;
                        end else begin
                            d.bitn = q.bitn + BW'(1);
                        end
                    end
                end else begin
                    d.cnt = q.cnt + DIV_W'(1);
                end
            end

            ST_TAIL: begin
                if (phase_end) begin
                    d.state = ST_IDLE;
                    d.cnt   = '0;
                    d.cs_n  = 1'b1;
                    d.valid = 1'b1;
                    d.res   = res_w;
                    d.sub   = sub_w;
                    d.err   = q.err_run;
                end else begin
                    d.cnt = q.cnt + DIV_W'(1);
                end
            end

            default: begin
                d.state = ST_IDLE;
                d.cs_n  = 1'b1;
                d.sclk  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cs_n  <= 1'b1;
            q.half  <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        cs_n_o       = q.cs_n;
        sclk_o       = q.sclk;
        mosi_o       = q.tx[FRAME_BITS-1];
        busy_o       = (q.state != ST_IDLE);
        result_o     = q.res;
        sub_o        = q.sub;
        valid_o      = q.valid;
        timing_err_o = q.err;
    end
endmodule

// File: rtl/adc_conv_reader_chk.sv
module adc_conv_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cs_n_o,
    input logic sclk_o,
    input logic mosi_o,
    input logic busy_o,
    input logic valid_o
);
    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R2
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && !$past(cs_n_o) && !$stable(mosi_o)) |-> $fell(sclk_o));

    // R3
    cs_fall_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !sclk_o);

    // R7
    valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && !$past(cs_n_o)));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8
    cs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));
endmodule

bind adc_conv_reader adc_conv_reader_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .busy_o  (busy_o),
    .valid_o (valid_o)
);

// File: tb/adc_conv_reader_bench.sv
`timescale 1ns/1ps
module adc_conv_reader_bench;
    localparam int DIV_W  = 10;
    localparam int BUDGET = 420;
    localparam real TCK   = 8.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] chan = '0;
    logic uni = 1'b0, sgl = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic miso = 1'b0;
    logic cs_n_w, sclk_w, mosi_w, busy_w, valid_w, err_w;
    logic [9:0] res_w;
    logic [1:0] sub_w;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int sl_idx = 0;
    int rises = 0;
    int cs_fall_cyc = 0;
    int first_rise_cyc = 0;
    logic [23:0] reply = '0;
    logic [23:0] cap = '0;

    always #(TCK/2) clk = ~clk;
    always @(negedge clk) cyc++;

    adc_conv_reader #(.DIV_W(DIV_W), .BUDGET_CYC(BUDGET)) u_adc_conv_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan),
        .unipolar_i(uni), .single_i(sgl), .div_i(div), .miso_i(miso),
        .cs_n_o(cs_n_w), .sclk_o(sclk_w), .mosi_o(mosi_w), .busy_o(busy_w),
        .result_o(res_w), .sub_o(sub_w), .valid_o(valid_w), .timing_err_o(err_w)
    );

    // model converter: shifts reply on falling clock, captures host data on rising
    always @(negedge sclk_w) begin
        sl_idx = sl_idx + 1;
        if (sl_idx < 24) miso = reply[23 - sl_idx];
        else             miso = 1'b0;
    end
    always @(posedge sclk_w) begin
        if (rises == 0) first_rise_cyc = cyc;
        cap   = {cap[22:0], mosi_w};
        rises = rises + 1;
    end
    always @(negedge cs_n_w) cs_fall_cyc = cyc;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input logic [2:0] c, input logic u, input logic s);
        return {1'b1, c[0], c[2], c[1], u, s, 2'b11};
    endfunction

    task automatic run_frame(input logic [2:0] c, input logic u, input logic s,
                             input logic [DIV_W-1:0] dv, input logic [23:0] rp, input bit poke);
        int h;
        int n;
        logic [9:0] r0;
        logic [1:0] s0;
        logic e0;
        h = (dv == 0) ? 1 : int'(dv);
        reply = rp; sl_idx = 0; miso = rp[23]; cap = '0; rises = 0;
        @(negedge clk);
        chan = c; uni = u; sgl = s; div = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0; chan = ~c; uni = ~u; sgl = ~s; div = dv + DIV_W'(3);
        n = 0;
        while (!valid_w && n < 5000) begin
            @(negedge clk);
            n++;
            if (poke && n == 5 * h) begin start = 1'b1; chan = c + 3'd1; end
            else start = 1'b0;
        end
        chk(n == 49 * h, "R7 completion cycle", n, 49 * h);
        chk(cs_n_w == 1'b1, "R7 select high at valid", cs_n_w, 1);
        chk(cs_fall_cyc + h == first_rise_cyc, "R3 first edge delay",
            first_rise_cyc - cs_fall_cyc, h);
        chk(rises == 24, "R2 clock count", rises, 24);
        chk(cap[23:16] == exp_cmd(c, u, s), "R4 command byte", cap[23:16], exp_cmd(c, u, s));
        chk(cap[15:0] == 16'h0, "R5 zero filler", cap[15:0], 0);
        chk(res_w == rp[14:5], "R6 result bits", res_w, rp[14:5]);
        chk(sub_w == rp[4:3], "R6 sub bits", sub_w, rp[4:3]);
        chk(err_w == (21 * h > BUDGET), "R9 timing flag", err_w, (21 * h > BUDGET));
        r0 = res_w; s0 = sub_w; e0 = err_w;
        @(negedge clk);
        chk(valid_w == 1'b0, "R7 valid one cycle", valid_w, 0);
        repeat (4 * h + 4) @(negedge clk);
        chk(cs_n_w == 1'b1 && rises == 24, "R8 no extra frame", {cs_n_w, 8'(rises)}, {1'b1, 8'd24});
        chk(res_w == r0 && sub_w == s0 && err_w == e0, "R10 outputs held",
            {err_w, sub_w, res_w}, {e0, s0, r0});
    endtask

    initial begin
        #(TCK * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n_w == 1 && sclk_w == 0 && mosi_w == 0 && valid_w == 0 && busy_w == 0,
            "R1 reset controls", {cs_n_w, sclk_w, mosi_w, valid_w, busy_w}, 5'b10000);
        chk(res_w == 0 && sub_w == 0 && err_w == 0, "R1 reset data", {err_w, sub_w, res_w}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_frame(3'd0, 1'b1, 1'b1, 10'd2, 24'hFF_7FE7, 1'b0); // R4 R6 all ones around zeros
        run_frame(3'd1, 1'b0, 1'b1, 10'd1, 24'h00_4018, 1'b0); // R3 fastest clock
        run_frame(3'd6, 1'b1, 1'b0, 10'd0, 24'hA5_0007, 1'b0); // R3 zero divider
        run_frame(3'd5, 1'b0, 1'b0, 10'd20, 24'h3C_2AB5, 1'b0); // R9 at budget
        run_frame(3'd3, 1'b1, 1'b1, 10'd21, 24'hC3_5548, 1'b0); // R9 over budget
        run_frame(3'd7, 1'b1, 1'b0, 10'd3, 24'h5A_1234, 1'b1); // R8 start while busy
        for (int i = 0; i < 16; i++) begin
            logic [2:0] c = 3'($urandom_range(0, 7));
            logic u = 1'($urandom_range(0, 1));
            logic s = 1'($urandom_range(0, 1));
            logic [DIV_W-1:0] dv = DIV_W'($urandom_range(1, 6));
            logic [23:0] rp = 24'($urandom());
            run_frame(c, u, s, dv, rp, 1'($urandom_range(0, 1)));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule